// File: doc/BRIEF.md
# Issue Queue Operand Wakeup

This block holds the waiting side of an out-of-order issue queue. Each slot keeps one instruction's left and right source physical tags, with a ready flag per operand. Every cycle, up to a configurable number of result tags are broadcast on parallel lanes, each lane with its own valid bit. Every slot compares both of its source tags against every lane at once. Any match on any lane sets that operand's ready flag, and the flag then holds until the slot is released.

A slot asks to be issued once both of its operands are ready. The requests come out as one vector with one bit per slot. The selection logic outside the block answers with a grant vector, and each grant releases its slot. Allocation writes one slot per cycle, at an index the caller chooses. An allocation also looks at the broadcast lanes of that same cycle, so a producer that completes while its consumer is being written is not missed.

Top module: `iq_wakeup`

## Requirements
- R1: After reset no slot is occupied and the request vector `req` is all zeros.
- R2: Allocating slot i with both initial ready flags set makes `req[i]` high in the cycle after the allocation edge.
- R3: A slot requests only when both its left and right ready flags are set; waking just one operand leaves `req[i]` low.
- R4: A valid broadcast on any lane k sets the ready flag of every operand whose tag equals that lane's tag. Lane k's tag sits in `bc_tags[k*TAG_W +: TAG_W]` and its valid bit is `bc_valid[k]`.
- R5: A broadcast lane whose valid bit is 0 never sets a ready flag, whatever tag it carries.
- R6: A broadcast in the same cycle as an allocation is seen by the new slot. A matching operand starts ready, and `req[i]` can rise in the very next cycle.
- R7: A ready flag stays set after the matching broadcast is gone, for as long as the slot stays occupied.
- R8: A grant on `grant[i]` frees slot i, and `req[i]` is low from the next cycle. A freed slot never requests again, even if its old tags are broadcast, until it is allocated anew.
- R9: A single broadcast tag wakes every occupied slot that waits on it, in the same cycle.
- R10: When both operands of a slot carry the same tag, one broadcast of that tag wakes both operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Write a new instruction into a slot this cycle |
| alloc_idx | input | $clog2(ENTRIES) | Slot being written |
| alloc_tag_l | input | TAG_W | Left source tag |
| alloc_rdy_l | input | 1 | Left operand already available |
| alloc_tag_r | input | TAG_W | Right source tag |
| alloc_rdy_r | input | 1 | Right operand already available |
| bc_valid | input | IW | Per-lane valid for the result-tag broadcast |
| bc_tags | input | IW*TAG_W | Broadcast tags, lane k at bits k*TAG_W upward |
| grant | input | ENTRIES | Per-slot release from the selection logic |
| req | output | ENTRIES | Per-slot issue request |

## Verification
The hardest case to reach from the ports is a broadcast that lands in the same edge as the allocation of its consumer. In that case the stored tags do not exist yet, and only the incoming tags can match. The bench drives both in one cycle, with the two tags on different lanes, and expects the request one edge later. It also places the same tag on every lane with all valid bits low. This separates the valid gating from the equality compare, and only after that does it raise a single lane.

// File: rtl/iqw_pkg.sv
package iqw_pkg;
    localparam int unsigned IQW_ENTRIES = 16;
    localparam int unsigned IQW_TAG_W   = 6;
    localparam int unsigned IQW_LANES   = 4;
endpackage

// File: rtl/iqw_tag_match.sv
module iqw_tag_match #(
    parameter int unsigned TAG_W = iqw_pkg::IQW_TAG_W,
    parameter int unsigned IW    = iqw_pkg::IQW_LANES
) (
    input  logic [TAG_W-1:0]    tag_i,
    input  logic [IW-1:0]       bc_valid_i,
    input  logic [IW*TAG_W-1:0] bc_tags_i,
    output logic                hit_o
);
    logic [IW-1:0] lane_eq;

    // One comparator per broadcast lane, gated by that lane's valid bit
    for (genvar k = 0; k < IW; k++) begin : g_lane
        assign lane_eq[k] = bc_valid_i[k] && (bc_tags_i[k*TAG_W +: TAG_W] == tag_i);
    end

    assign hit_o = |lane_eq;
endmodule

// File: rtl/iqw_slot.sv
module iqw_slot #(
    parameter int unsigned TAG_W = iqw_pkg::IQW_TAG_W,
    parameter int unsigned IW    = iqw_pkg::IQW_LANES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_i,
    input  logic [TAG_W-1:0]    alloc_tag_l_i,
    input  logic                alloc_rdy_l_i,
    input  logic [TAG_W-1:0]    alloc_tag_r_i,
    input  logic                alloc_rdy_r_i,
    input  logic                grant_i,
    input  logic [IW-1:0]       bc_valid_i,
    input  logic [IW*TAG_W-1:0] bc_tags_i,
    output logic                req_o
);
    typedef struct packed {
        logic             busy;
        logic [TAG_W-1:0] tag_l;
        logic             rdy_l;
        logic [TAG_W-1:0] tag_r;
        logic             rdy_r;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  hit_l, hit_r;

    iqw_tag_match #(.TAG_W(TAG_W), .IW(IW)) u_match_l (
        .tag_i      (slot_q.tag_l),
        .bc_valid_i (bc_valid_i),
        .bc_tags_i  (bc_tags_i),
        .hit_o      (hit_l)
    );

    iqw_tag_match #(.TAG_W(TAG_W), .IW(IW)) u_match_r (
        .tag_i      (slot_q.tag_r),
        .bc_valid_i (bc_valid_i),
        .bc_tags_i  (bc_tags_i),
        .hit_o      (hit_r)
    );

    always_comb begin
        slot_d = slot_q;
        if (alloc_i) begin
            // A new write wins over a release of the same slot
            slot_d.busy  = 1'b1;
            slot_d.tag_l = alloc_tag_l_i;
            slot_d.rdy_l = alloc_rdy_l_i;
            slot_d.tag_r = alloc_tag_r_i;
            slot_d.rdy_r = alloc_rdy_r_i;
        end else if (grant_i) begin
            slot_d.busy  = 1'b0;
            slot_d.rdy_l = 1'b0;
            slot_d.rdy_r = 1'b0;
        end else if (slot_q.busy) begin
            slot_d.rdy_l = slot_q.rdy_l | hit_l;
            slot_d.rdy_r = slot_q.rdy_r | hit_r;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign req_o = slot_q.busy & slot_q.rdy_l & slot_q.rdy_r;

    // R7: a set flag survives while the slot stays occupied
    a_r7_sticky_left: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.busy && slot_q.rdy_l && !alloc_i && !grant_i) |=> slot_q.rdy_l);
    a_r7_sticky_right: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.busy && slot_q.rdy_r && !alloc_i && !grant_i) |=> slot_q.rdy_r);

    // R5: with every lane invalid, no ready flag changes
    a_r5_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.busy && !alloc_i && !grant_i && bc_valid_i == '0)
        |=> ($stable(slot_q.rdy_l) && $stable(slot_q.rdy_r)));

    // R6: a ready indication given at allocation is kept
    a_r6_alloc_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && alloc_rdy_l_i && alloc_rdy_r_i) |=> req_o);

    // R8: a release without a new write drops the request
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i && !alloc_i) |=> !req_o);

    // R3: an unwoken left operand keeps the request low
    a_r3_need_both: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.busy && !alloc_i && !grant_i && !slot_q.rdy_l && !hit_l) |=> !req_o);
endmodule

// File: rtl/iq_wakeup.sv
module iq_wakeup #(
    parameter int unsigned ENTRIES = iqw_pkg::IQW_ENTRIES,
    parameter int unsigned TAG_W   = iqw_pkg::IQW_TAG_W,
    parameter int unsigned IW      = iqw_pkg::IQW_LANES,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_valid,
    input  logic [IDX_W-1:0]    alloc_idx,
    input  logic [TAG_W-1:0]    alloc_tag_l,
    input  logic                alloc_rdy_l,
    input  logic [TAG_W-1:0]    alloc_tag_r,
    input  logic                alloc_rdy_r,
    input  logic [IW-1:0]       bc_valid,
    input  logic [IW*TAG_W-1:0] bc_tags,
    input  logic [ENTRIES-1:0]  grant,
    output logic [ENTRIES-1:0]  req
);
    logic bypass_l, bypass_r;
    logic start_rdy_l, start_rdy_r;

    // One shared compare for the incoming tags: only one slot is written per cycle
    iqw_tag_match #(.TAG_W(TAG_W), .IW(IW)) u_alloc_match_l (
        .tag_i      (alloc_tag_l),
        .bc_valid_i (bc_valid),
        .bc_tags_i  (bc_tags),
        .hit_o      (bypass_l)
    );

    iqw_tag_match #(.TAG_W(TAG_W), .IW(IW)) u_alloc_match_r (
        .tag_i      (alloc_tag_r),
        .bc_valid_i (bc_valid),
        .bc_tags_i  (bc_tags),
        .hit_o      (bypass_r)
    );

    assign start_rdy_l = alloc_rdy_l | bypass_l;
    assign start_rdy_r = alloc_rdy_r | bypass_r;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic wr_here;
        assign wr_here = alloc_valid && (alloc_idx == IDX_W'(g));

        iqw_slot #(.TAG_W(TAG_W), .IW(IW)) u_slot (
            .clk           (clk),
            .rst_n         (rst_n),
            .alloc_i       (wr_here),
            .alloc_tag_l_i (alloc_tag_l),
            .alloc_rdy_l_i (start_rdy_l),
            .alloc_tag_r_i (alloc_tag_r),
            .alloc_rdy_r_i (start_rdy_r),
            .grant_i       (grant[g]),
            .bc_valid_i    (bc_valid),
            .bc_tags_i     (bc_tags),
            .req_o         (req[g])
        );
    end

    // R6: a same-cycle match on both incoming tags yields a request next cycle
    a_r6_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && bypass_l && bypass_r) |=> req[$past(alloc_idx)]);
endmodule

// File: tb/iq_wakeup_tb.sv
`timescale 1ns/1ps
module iq_wakeup_tb_top;
    localparam int N  = 16;
    localparam int TW = 6;
    localparam int IW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            alloc_valid;
    logic [3:0]      alloc_idx;
    logic [TW-1:0]   alloc_tag_l, alloc_tag_r;
    logic            alloc_rdy_l, alloc_rdy_r;
    logic [IW-1:0]   bc_valid;
    logic [IW*TW-1:0] bc_tags;
    logic [N-1:0]    grant;
    logic [N-1:0]    req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    iq_wakeup dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_idx(alloc_idx),
        .alloc_tag_l(alloc_tag_l), .alloc_rdy_l(alloc_rdy_l),
        .alloc_tag_r(alloc_tag_r), .alloc_rdy_r(alloc_rdy_r),
        .bc_valid(bc_valid), .bc_tags(bc_tags),
        .grant(grant), .req(req)
    );

    task automatic idle();
        alloc_valid = 1'b0; alloc_idx = '0;
        alloc_tag_l = '0; alloc_tag_r = '0;
        alloc_rdy_l = 1'b0; alloc_rdy_r = 1'b0;
        bc_valid = '0; bc_tags = '0; grant = '0;
    endtask

    // Inputs set at a falling edge are taken at the next rising edge; look again at the following falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic check(string rq, logic [N-1:0] act, logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: req=%h expected %h", rq, act, exp);
        end
    endtask

    task automatic put(int idx, int tl, bit rl, int tr, bit rr);
        alloc_valid = 1'b1; alloc_idx = 4'(idx);
        alloc_tag_l = TW'(tl); alloc_rdy_l = rl;
        alloc_tag_r = TW'(tr); alloc_rdy_r = rr;
    endtask

    task automatic lane(int k, int tag);
        bc_valid[k] = 1'b1;
        bc_tags[k*TW +: TW] = TW'(tag);
    endtask

    task automatic clear_all();
        grant = '1;
        step();
        check("R8", req, '0);
    endtask

    task automatic t_reset();
        check("R1", req, '0);
    endtask

    task automatic t_alloc_ready();
        put(3, 5, 1, 7, 1);
        step();
        check("R2", req, 16'h0008);
        grant[3] = 1'b1;
        step();
        check("R8", req, '0);
        lane(0, 5); lane(1, 7);
        step();
        check("R8", req, '0);
    endtask

    task automatic t_lanes();
        for (int k = 0; k < IW; k++) begin
            put(k + 4, 10 + k, 0, 0, 1);
            step();
            check("R4", req, '0);
            lane(k, 10 + k);
            step();
            check("R4", req, N'(1) << (k + 4));
            grant[k + 4] = 1'b1;
            step();
        end
    endtask

    task automatic t_two_op();
        put(0, 20, 0, 21, 0);
        step();
        lane(1, 20);
        step();
        check("R3", req, '0);
        step();
        check("R3", req, '0);
        lane(2, 21);
        step();
        check("R7", req, 16'h0001);
        step(); step();
        check("R7", req, 16'h0001);
        clear_all();
    endtask

    task automatic t_invalid();
        put(1, 30, 0, 30, 0);
        step();
        for (int k = 0; k < IW; k++) bc_tags[k*TW +: TW] = TW'(30);
        step();
        check("R5", req, '0);
        lane(3, 30);
        step();
        check("R10", req, 16'h0002);
        clear_all();
    endtask

    task automatic t_same_cycle();
        put(2, 40, 0, 41, 0);
        lane(0, 40); lane(3, 41);
        step();
        check("R6", req, 16'h0004);
        clear_all();
    endtask

    task automatic t_fanout();
        put(8, 50, 0, 1, 1);  step();
        put(9, 50, 0, 2, 1);  step();
        put(10, 50, 0, 3, 1); step();
        check("R9", req, '0);
        lane(2, 50);
        step();
        check("R9", req, 16'h0700);
        clear_all();
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_alloc_ready();
        t_lanes();
        t_two_op();
        t_invalid();
        t_same_cycle();
        t_fanout();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule